// File: doc/BRIEF.md
# Triple-Redundant Voted Up-Counter

This block is a free-running synchronous up-counter built to survive single-event upsets in its state flops. It holds three separate copies of the count, each a register of the same width on the one system clock. A per-bit two-of-three majority vote is taken across the copies. The voted word is the visible count, and the voted word plus one is loaded into every copy on each rising edge. Because all three copies are reloaded from the vote, a copy that has been upset agrees with the other two again after a single edge. The counter is therefore always correct after any one flip.

No flop output drives a clock pin anywhere in the block, so it is not a ripple counter. An active-low asynchronous reset clears all three copies. A fault-injection port lets a test flip one chosen bit of one chosen copy as that copy is loaded, so that the masking can be exercised without radiation.

Top module: `tmr_voted_counter`

## Requirements
- R1: With reset released, every rising edge of `clk_i` raises `count_o` by exactly one. All copies are clocked by `clk_i` alone.
- R2: While `rst_ni` is low, `count_o` reads zero. The clear takes effect at once, without waiting for a clock edge, and holds across edges.
- R3: When `count_o` is all ones, the next edge brings it to zero.
- R4: Each bit of `count_o` is the two-of-three majority of that bit in the three copies, so at most one copy may differ from the output at any time.
- R5: All three copies load the voted count plus one, never their own value plus one. A copy that was upset equals the other two after the next edge. Repeated single flips on the same bit of different copies in successive cycles therefore never reach `count_o`.
- R6: An edge with `inj_stb_i` high and `inj_copy_i` equal to 0, 1 or 2 stores the incremented count with bit `inj_bit_i` inverted into copy 0, 1 or 2 respectively. `count_o` still shows the correct count after that edge.
- R7: Copy code 3 on `inj_copy_i` selects no copy. A strobe with it changes no copy and has no effect on `count_o`.
- R8: The width `W` is a parameter with default 4. `inj_bit_i` is ceil(log2(W)) bits wide, with a minimum of 1. A bit index of W or above flips nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; rising edge advances the count |
| rst_ni | input | 1 | Asynchronous active-low clear of all copies |
| inj_stb_i | input | 1 | Fault-injection strobe, sampled at the rising edge |
| inj_copy_i | input | 2 | Copy to corrupt: 0, 1, 2; 3 selects none |
| inj_bit_i | input | IDX_W | Index of the bit to invert in the selected copy |
| count_o | output | W | Majority-voted count |

## Verification
The case that is hardest to reach from the ports is a copy that disagrees with the other two. It never arises in normal running, and when a flip does land it is invisible at `count_o` by design. The stimulus creates disagreement on purpose through the injection port. It flips the same bit in copy 0, then copy 1, then copy 2 on consecutive edges. A copy that failed to reconverge would then line up with a freshly flipped one, and the vote on that bit would go wrong. This sweep is repeated for every bit position and at many count values, including across the wrap.

// File: rtl/tmr_cnt_pkg.sv
package tmr_cnt_pkg;

    localparam int unsigned NUM_COPIES = 3;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_NONE = 2'd3
    } copy_sel_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/tmr_cnt_voter.sv
module tmr_cnt_voter #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] v_o
);
    import tmr_cnt_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb v_o[i] = maj3(a_i[i], b_i[i], c_i[i]);
    end

endmodule

// File: rtl/tmr_cnt_fault_mask.sv
module tmr_cnt_fault_mask #(
    parameter int unsigned W     = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic                                         stb_i,
    input  logic [1:0]                                   copy_i,
    input  logic [IDX_W-1:0]                             bit_i,
    output logic [tmr_cnt_pkg::NUM_COPIES-1:0][W-1:0]    flip_o
);
    import tmr_cnt_pkg::*;

    logic          idx_ok;
    logic [W-1:0]  onehot;

    always_comb begin
        idx_ok = (int'(bit_i) < int'(W));
        onehot = idx_ok ? (W'(1) << bit_i) : '0;
    end

    for (genvar g = 0; g < NUM_COPIES; g++) begin : g_copy
        always_comb flip_o[g] = (stb_i && (copy_i == 2'(g))) ? onehot : '0;
    end

endmodule

// File: rtl/tmr_cnt_copy.sv
module tmr_cnt_copy #(
    parameter int unsigned W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] next_i,
    input  logic [W-1:0] flip_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb cnt_d = next_i ^ flip_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign q_o = cnt_q;

endmodule

// File: rtl/tmr_voted_counter.sv
module tmr_voted_counter #(
    parameter int unsigned W     = 4,
    parameter int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inj_stb_i,
    input  logic [1:0]       inj_copy_i,
    input  logic [IDX_W-1:0] inj_bit_i,
    output logic [W-1:0]     count_o
);
    import tmr_cnt_pkg::*;

    typedef struct packed {
        logic [W-1:0] inc;
    } nxt_t;

    logic [NUM_COPIES-1:0][W-1:0] copy_q;
    logic [NUM_COPIES-1:0][W-1:0] flip;
    logic [W-1:0]                 voted;
    nxt_t                         nxt_d;

    tmr_cnt_voter #(.W(W)) u_vote (
        .a_i (copy_q[0]),
        .b_i (copy_q[1]),
        .c_i (copy_q[2]),
        .v_o (voted)
    );

    tmr_cnt_fault_mask #(.W(W), .IDX_W(IDX_W)) u_mask (
        .stb_i  (inj_stb_i),
        .copy_i (inj_copy_i),
        .bit_i  (inj_bit_i),
        .flip_o (flip)
    );

    always_comb nxt_d.inc = voted + W'(1);

    for (genvar g = 0; g < NUM_COPIES; g++) begin : g_copy
        tmr_cnt_copy #(.W(W)) u_copy (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .next_i (nxt_d.inc),
            .flip_i (flip[g]),
            .q_o    (copy_q[g])
        );
    end

    assign count_o = voted;

    // R1: one step per edge
    p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> count_o == $past(count_o) + W'(1));

    // R3: wrap from all ones
    p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o == {W{1'b1}}) |=> (count_o == '0));

    // R4: never more than one copy away from the vote
    p_single_dev_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({copy_q[0] != voted, copy_q[1] != voted, copy_q[2] != voted}) <= 1);

    // R5, R7: with no valid injection all copies agree after the edge
    p_reconverge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(inj_stb_i && inj_copy_i != SEL_NONE) |=>
        (copy_q[0] == copy_q[1]) && (copy_q[1] == copy_q[2]));

    // R6: a valid injection makes the chosen copy differ from its neighbour
    for (genvar g = 0; g < NUM_COPIES; g++) begin : g_hit_chk
        p_inject_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (inj_stb_i && inj_copy_i == 2'(g) && int'(inj_bit_i) < int'(W)) |=>
            (copy_q[g] != copy_q[(g + 1) % NUM_COPIES]));
    end

endmodule

// File: tb/sim_tmr_voted_counter.sv
`timescale 1ns/1ps
module sim_tmr_voted_counter;
    localparam int unsigned W     = 4;
    localparam int unsigned IDX_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             stb = 1'b0;
    logic [1:0]       csel = 2'd0;
    logic [IDX_W-1:0] bsel = '0;
    logic [W-1:0]     count;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] exp_cnt = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmr_voted_counter #(.W(W), .IDX_W(IDX_W)) u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .inj_stb_i  (stb),
        .inj_copy_i (csel),
        .inj_bit_i  (bsel),
        .count_o    (count)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] e);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: count actual %0d expected %0d at %0t", req, act, e, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) exp_cnt = exp_cnt + W'(1);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R2: reset state, held across edges
        #1;
        chk("R2", count, '0);
        repeat (3) @(negedge clk);
        chk("R2", count, '0);
        rst_n = 1'b1;
        exp_cnt = '0;

        // R1 / R3: plain counting through two wraps
        for (int i = 0; i < 40; i++) begin
            tick();
            chk((exp_cnt == '0) ? "R3" : "R1", count, exp_cnt);
        end

        // R6 / R5: same bit into copies 0,1,2 on consecutive edges
        for (int b = 0; b < int'(W); b++) begin
            for (int c = 0; c < 3; c++) begin
                stb = 1'b1; csel = 2'(c); bsel = IDX_W'(b);
                tick();
                chk("R6", count, exp_cnt);
            end
            stb = 1'b0;
            tick();
            chk("R5", count, exp_cnt);
        end

        // R5: single flips separated by idle edges, every copy and bit
        for (int c = 0; c < 3; c++) begin
            for (int b = 0; b < int'(W); b++) begin
                stb = 1'b1; csel = 2'(c); bsel = IDX_W'(b);
                tick();
                stb = 1'b0;
                chk("R6", count, exp_cnt);
                tick();
                chk("R5", count, exp_cnt);
            end
        end

        // R4: continuous rotating injection for many edges
        for (int i = 0; i < 60; i++) begin
            stb = 1'b1; csel = 2'(i % 3); bsel = IDX_W'((i / 3) % W);
            tick();
            chk("R4", count, exp_cnt);
        end
        stb = 1'b0;

        // R7: copy code 3 selects nothing
        for (int b = 0; b < int'(W); b++) begin
            stb = 1'b1; csel = 2'd3; bsel = IDX_W'(b);
            tick();
            chk("R7", count, exp_cnt);
        end
        stb = 1'b0;
        tick();
        chk("R7", count, exp_cnt);

        // R2: asynchronous clear mid-run, no clock edge needed
        #1 rst_n = 1'b0;
        #0.5;
        chk("R2", count, '0);
        repeat (2) @(negedge clk);
        chk("R2", count, '0);
        rst_n = 1'b1;
        exp_cnt = '0;

        // R8: full cycle at default width after re-start
        for (int i = 0; i < 18; i++) begin
            tick();
            chk("R8", count, exp_cnt);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule